// File: doc/BRIEF.md
# Interrupt CPU Interface with Running Priority

This block connects the interrupt sources of a chip to one processor. Each source has a priority, where a lower number is more urgent, and an enable bit. A source becomes pending when it sends a one-cycle set pulse. Every cycle the block searches the enabled, pending sources for the most urgent one that beats a programmable priority mask. It registers that source's ID as the highest-pending ID and drives an interrupt request line to the processor from it.

The processor takes an interrupt with an acknowledge read. The read returns the ID of the highest-pending source. The block then moves that source from pending to active. When the handler finishes, the processor writes the same ID as an end-of-interrupt, and the block clears the active bit. The block also reports a running priority, which is the most urgent priority among all active sources. A distributor enable and a CPU-interface enable together gate both the request line and acknowledge.

Top module: `irq_cpu_if`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows: `hp_id` is the spurious ID 1023, `irq_out` is 0, all pending and active bits are 0, `run_prio` is 0xFF and `eoi_err` is 0.
- R2: The search considers only sources that are both enabled and pending, and uses `prio_mask` as its starting threshold. A source qualifies only if its priority is strictly lower numerically than the threshold, and the lowest priority value wins. The result appears on `hp_id` at the clock edge after the pending bit is visible.
- R3: When two qualifying sources have equal priority, the one with the lower ID wins.
- R4: When no source qualifies, `hp_id` is 1023. This covers a mask of 0, a disabled source, and a priority equal to the mask.
- R5: `irq_out` is 1 only if a source qualified in the previous cycle and both `dist_en` and `cpu_en` were 1. It is registered together with `hp_id`.
- R6: An acknowledge (`ack_req`=1) with both enables set works as follows:
  - In the same cycle, `ack_id` shows the registered `hp_id`.
  - At the clock edge, the block sets that source's active bit and clears its pending bit. It also sets `hp_id` to 1023 and `irq_out` to 0.
  - At the next edge, the search result from the remaining pending sources appears.
- R7: An acknowledge with either enable clear returns 1023 on `ack_id` and changes no pending or active bit.
- R8: An end-of-interrupt (`eoi_req`=1) naming an active ID clears that ID's active bit at the clock edge.
- R9: An end-of-interrupt naming an ID that is not active, or that is out of range, sets the sticky flag `eoi_err`. It leaves the active bits unchanged, and only reset clears the flag.
- R10: `run_prio` is combinational. It equals the minimum priority over the active sources, or 0xFF if no source is active. It follows acknowledge, end-of-interrupt and priority changes without an added cycle.
- R11: A `pend_set` pulse sets the pending bit at the clock edge whether or not the source is enabled. The bit stays set until that source is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dist_en | input | 1 | Distributor enable |
| cpu_en | input | 1 | CPU-interface enable |
| prio_mask | input | 8 | Priority mask; start threshold of the search |
| irq_prio | input | NUM_IRQ*8 | Priority of source i in bits [8i+7:8i] |
| irq_enable | input | NUM_IRQ | Per-source enable |
| pend_set | input | NUM_IRQ | One-cycle pending set pulses |
| ack_req | input | 1 | Acknowledge read strobe |
| ack_id | output | 10 | ID returned by the acknowledge read |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | ID written by end-of-interrupt |
| irq_out | output | 1 | Interrupt request to the processor |
| hp_id | output | 10 | Registered highest-pending ID |
| run_prio | output | 8 | Running priority |
| pending | output | NUM_IRQ | Pending bits |
| active | output | NUM_IRQ | Active bits |
| eoi_err | output | 1 | Sticky bad end-of-interrupt flag |

## Verification
The assertions check several properties on every cycle:
- the request line never rises without a real winner;
- an accepted acknowledge always leaves the spurious ID and a low request line one cycle later;
- a blocked acknowledge never alters the active set;
- a good end-of-interrupt removes exactly one active bit;
- the error flag never falls;
- an idle active set reads 0xFF.

Only the directed scenarios can show the actual winner chosen among competing priorities, the tie order, and the exact mask boundary. They also show the sequence of acknowledged IDs and the running-priority values that follow nested acknowledges and end-of-interrupt writes.

// File: rtl/ici_pkg.sv
// Package: shared widths and constant codes for the interrupt CPU interface.
// Assumes one processor and 8-bit priorities where lower means more urgent.
package ici_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;
    localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
    localparam logic [PRIO_W-1:0] PRIO_IDLE   = 8'hFF;
endpackage

// File: rtl/ici_pend_search.sv
// Module: combinational highest-pending search.
// Scans candidates in ascending ID order and keeps the first strictly better
// priority, so ties go to the lower ID. Starts from the given threshold.
// Assumes NUM_IRQ is below the spurious ID.
module ici_pend_search
    import ici_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]        cand,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         start,
    output logic                      found,
    output logic [ID_W-1:0]           idx,
    output logic [PRIO_W-1:0]         best
);
    // Linear scan for the lowest qualifying priority.
    always_comb begin
        found = 1'b0;
        idx   = SPURIOUS_ID;
        best  = start;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (prio[i*PRIO_W +: PRIO_W] < best)) begin
                found = 1'b1;
                idx   = ID_W'(i);
                best  = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/ici_run_prio.sv
// Module: running priority, the minimum priority over active sources.
// Gives the idle code when nothing is active. Purely combinational, so it
// follows active-set and priority changes at once.
module ici_run_prio
    import ici_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]        active,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio,
    output logic [PRIO_W-1:0]         run_prio
);
    // Minimum over the active set.
    always_comb begin
        run_prio = PRIO_IDLE;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (active[i] && (prio[i*PRIO_W +: PRIO_W] < run_prio))
                run_prio = prio[i*PRIO_W +: PRIO_W];
        end
    end
endmodule

// File: rtl/ici_state.sv
// Module: per-source pending and active bits, plus the sticky EOI error flag.
// A set pulse wins over an acknowledge clear of the same source in one cycle.
// Assumes ack_fire is already gated by both enables in the parent.
module ici_state
    import ici_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] pend_set,
    input  logic               ack_fire,
    input  logic [ID_W-1:0]    ack_sel,
    input  logic               eoi_req,
    input  logic [ID_W-1:0]    eoi_id,
    output logic [NUM_IRQ-1:0] pending,
    output logic [NUM_IRQ-1:0] active,
    output logic               eoi_err
);
    logic [NUM_IRQ-1:0] ack_hit;
    logic [NUM_IRQ-1:0] eoi_hit;
    logic               eoi_ok;

    // One-hot decode of the acknowledged and retired IDs.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_dec
        assign ack_hit[g] = ack_fire && (ack_sel == ID_W'(g));
        assign eoi_hit[g] = eoi_req && (eoi_id == ID_W'(g));
    end

    assign eoi_ok = |(eoi_hit & active);

    // Pending: set by pulses, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~ack_hit) | pend_set;
    end

    // Active: set by acknowledge, cleared by a valid end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= '0;
        else        active <= (active & ~(eoi_ok ? eoi_hit : '0)) | ack_hit;
    end

    // Sticky error on an end-of-interrupt naming a non-active ID.
    always_ff @(posedge clk) begin
        if (!rst_n)                 eoi_err <= 1'b0;
        else if (eoi_req && !eoi_ok) eoi_err <= 1'b1;
    end

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_err |=> eoi_err);

    a_r8_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_ok && !ack_fire) |=> ($countones(active) == $past($countones(active)) - 1));

    a_r9_bad_eoi_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !eoi_ok && !ack_fire) |=> $stable(active));
endmodule

// File: rtl/irq_cpu_if.sv
// Module: interrupt CPU interface for a single processor.
// Registers the highest-pending ID and the request line, serves acknowledge
// reads and end-of-interrupt writes, and reports the running priority.
// Assumes acknowledge data is taken in the same cycle as ack_req.
module irq_cpu_if
    import ici_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dist_en,
    input  logic                      cpu_en,
    input  logic [PRIO_W-1:0]         prio_mask,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [NUM_IRQ-1:0]        irq_enable,
    input  logic [NUM_IRQ-1:0]        pend_set,
    input  logic                      ack_req,
    output logic [ID_W-1:0]           ack_id,
    input  logic                      eoi_req,
    input  logic [ID_W-1:0]           eoi_id,
    output logic                      irq_out,
    output logic [ID_W-1:0]           hp_id,
    output logic [PRIO_W-1:0]         run_prio,
    output logic [NUM_IRQ-1:0]        pending,
    output logic [NUM_IRQ-1:0]        active,
    output logic                      eoi_err
);
    logic              both_en;
    logic              ack_fire;
    logic              srch_found;
    logic [ID_W-1:0]   srch_idx;
    logic [PRIO_W-1:0] srch_best;

    assign both_en  = dist_en && cpu_en;
    assign ack_fire = ack_req && both_en;
    assign ack_id   = ack_fire ? hp_id : SPURIOUS_ID;

    ici_state #(.NUM_IRQ(NUM_IRQ)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_set (pend_set),
        .ack_fire (ack_fire),
        .ack_sel  (hp_id),
        .eoi_req  (eoi_req),
        .eoi_id   (eoi_id),
        .pending  (pending),
        .active   (active),
        .eoi_err  (eoi_err)
    );

    ici_pend_search #(.NUM_IRQ(NUM_IRQ)) u_search (
        .cand  (pending & irq_enable),
        .prio  (irq_prio),
        .start (prio_mask),
        .found (srch_found),
        .idx   (srch_idx),
        .best  (srch_best)
    );

    ici_run_prio #(.NUM_IRQ(NUM_IRQ)) u_runp (
        .active   (active),
        .prio     (irq_prio),
        .run_prio (run_prio)
    );

    // Highest-pending ID: spurious after an acknowledge, else the search result.
    always_ff @(posedge clk) begin
        if (!rst_n)        hp_id <= SPURIOUS_ID;
        else if (ack_fire) hp_id <= SPURIOUS_ID;
        else               hp_id <= srch_idx;
    end

    // Request line: a winner strictly below the mask and both enables set.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_out <= 1'b0;
        else if (ack_fire) irq_out <= 1'b0;
        else               irq_out <= both_en && srch_found && (srch_best < prio_mask);
    end

    a_r5_irq_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (hp_id != SPURIOUS_ID));

    a_r6_ack_clears_hp: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> ((hp_id == SPURIOUS_ID) && !irq_out));

    a_r7_blocked_ack_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !both_en && !eoi_req) |=> $stable(active));

    a_r10_idle_run_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> (run_prio == PRIO_IDLE));

    a_r2_found_beats_mask: assert property (@(posedge clk) disable iff (!rst_n)
        srch_found |-> (srch_best < prio_mask));
endmodule

// File: tb/irq_cpu_if_test.sv
module irq_cpu_if_test;
    localparam int N = 64;
    localparam logic [9:0] SPUR = 10'd1023;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            dist_en, cpu_en;
    logic [7:0]      prio_mask;
    logic [N*8-1:0]  irq_prio;
    logic [N-1:0]    irq_enable, pend_set;
    logic            ack_req, eoi_req;
    logic [9:0]      eoi_id, ack_id, hp_id;
    logic            irq_out, eoi_err;
    logic [7:0]      run_prio;
    logic [N-1:0]    pending, active;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    irq_cpu_if #(.NUM_IRQ(N)) uut (
        .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
        .prio_mask(prio_mask), .irq_prio(irq_prio), .irq_enable(irq_enable),
        .pend_set(pend_set), .ack_req(ack_req), .ack_id(ack_id),
        .eoi_req(eoi_req), .eoi_id(eoi_id), .irq_out(irq_out), .hp_id(hp_id),
        .run_prio(run_prio), .pending(pending), .active(active), .eoi_err(eoi_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_prio(input int i, input logic [7:0] p);
        irq_prio[i*8 +: 8] = p;
    endtask

    task automatic pulse(input logic [N-1:0] v);
        pend_set = v;
        tick();
        pend_set = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; dist_en = 1'b1; cpu_en = 1'b1; prio_mask = 8'hF0;
        irq_prio = '1; irq_enable = '1; pend_set = '0;
        ack_req = 1'b0; eoi_req = 1'b0; eoi_id = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 hp_id", hp_id, SPUR);
        chk("R1 irq_out", irq_out, 0);
        chk("R1 pending", pending, 0);
        chk("R1 active", active, 0);
        chk("R1 run_prio", run_prio, 8'hFF);
        chk("R1 eoi_err", eoi_err, 0);
    endtask

    task automatic t_search_and_ack();
        do_reset();
        set_prio(5, 8'h40); set_prio(9, 8'h20);
        pulse((64'd1 << 5) | (64'd1 << 9));
        chk("R11 pending set", pending, (64'd1 << 5) | (64'd1 << 9));
        tick();
        chk("R2 lowest wins", hp_id, 10'd9);
        chk("R5 irq asserted", irq_out, 1);
        ack_req = 1'b1; #1;
        chk("R6 ack_id", ack_id, 10'd9);
        tick(); ack_req = 1'b0;
        chk("R6 active set", active, 64'd1 << 9);
        chk("R6 pending cleared", pending, 64'd1 << 5);
        chk("R6 hp spurious", hp_id, SPUR);
        chk("R6 irq dropped", irq_out, 0);
        chk("R10 run_prio one", run_prio, 8'h20);
        tick();
        chk("R6 research", hp_id, 10'd5);
        ack_req = 1'b1; tick(); ack_req = 1'b0;
        chk("R10 run_prio nested", run_prio, 8'h20);
        eoi_req = 1'b1; eoi_id = 10'd9; tick(); eoi_req = 1'b0;
        chk("R8 eoi clears", active, 64'd1 << 5);
        chk("R10 run_prio after eoi", run_prio, 8'h40);
        set_prio(5, 8'h10); #1;
        chk("R10 prio change", run_prio, 8'h10);
        eoi_req = 1'b1; eoi_id = 10'd5; tick(); eoi_req = 1'b0;
        chk("R8 eoi last", active, 0);
        chk("R10 run_prio idle", run_prio, 8'hFF);
        chk("R8 no error", eoi_err, 0);
    endtask

    task automatic t_tie();
        do_reset();
        set_prio(20, 8'h30); set_prio(12, 8'h30);
        pulse((64'd1 << 20) | (64'd1 << 12));
        tick();
        chk("R3 tie lower id", hp_id, 10'd12);
    endtask

    task automatic t_mask();
        do_reset();
        set_prio(7, 8'h80); prio_mask = 8'h80;
        pulse(64'd1 << 7); tick();
        chk("R4 equal to mask", hp_id, SPUR);
        chk("R5 no irq at mask", irq_out, 0);
        prio_mask = 8'h81; tick();
        chk("R2 below mask", hp_id, 10'd7);
        prio_mask = 8'h00; tick();
        chk("R4 mask zero", hp_id, SPUR);
        prio_mask = 8'hF0; irq_enable[7] = 1'b0; tick();
        chk("R4 disabled source", hp_id, SPUR);
        chk("R11 pending held", pending, 64'd1 << 7);
    endtask

    task automatic t_gating();
        do_reset();
        set_prio(3, 8'h10); dist_en = 1'b0;
        pulse(64'd1 << 3); tick();
        chk("R5 hp without enable", hp_id, 10'd3);
        chk("R5 irq gated dist", irq_out, 0);
        ack_req = 1'b1; #1;
        chk("R7 ack spurious", ack_id, SPUR);
        tick(); ack_req = 1'b0;
        chk("R7 active unchanged", active, 0);
        chk("R7 pending unchanged", pending, 64'd1 << 3);
        dist_en = 1'b1; cpu_en = 1'b0; tick();
        chk("R5 irq gated cpu", irq_out, 0);
        cpu_en = 1'b1; tick();
        chk("R5 irq both", irq_out, 1);
    endtask

    task automatic t_eoi_err();
        do_reset();
        eoi_req = 1'b1; eoi_id = 10'd3; tick(); eoi_req = 1'b0;
        chk("R9 err set", eoi_err, 1);
        chk("R9 active unchanged", active, 0);
        tick(); tick();
        chk("R9 sticky", eoi_err, 1);
        do_reset();
        eoi_req = 1'b1; eoi_id = SPUR; tick(); eoi_req = 1'b0;
        chk("R9 out of range", eoi_err, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_search_and_ack();
        t_tie();
        t_mask();
        t_gating();
        t_eoi_err();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule